// File: doc/BRIEF.md
# Port A Address-20 Mask and Fast Reset Control

This block is an 8-bit legacy control register decoded at I/O address 092h. It holds two live bits. Bit 1 is the address-line-20 gate: clearing it asserts an internal active-low A20 mask, and setting it releases the mask. Bit 0 is a fast warm-reset request.

Bit 1 always shows the present gate state. Software can change it with a bus write. A keyboard-command monitor outside this block can also change it through a one-cycle update strobe. Every change of bit 1 raises a one-cycle system-management event pulse while the external event enable is high.

A 0-to-1 transition of bit 0 raises a one-cycle warm-reset request pulse. Software must write bit 0 back to 0 before it can request another reset. The upper six bits are reserved. Writes to them are dropped and they always read as zero.

Top module: `porta_ctl_reg`

## Requirements
- R1: After reset the register reads 02h, a20_mask_n is 1, and both warm_rst_req and smi_a20_evt are 0.
- R2: A write with io_addr equal to 092h loads io_wdata[1] into bit 1 and io_wdata[0] into bit 0. A write to any other address changes nothing.
- R3: Read-back bits 7:2 are always 0, whatever was written to them.
- R4: a20_mask_n equals bit 1, so a 0 in bit 1 drives the mask low (asserted). The output changes only on the clock edge after a register write or a keyboard update.
- R5: When kbd_upd is high and no write to 092h happens in that cycle, bit 1 takes kbd_a20 at the next edge. When both happen in the same cycle, the bus write value wins.
- R6: smi_a20_evt is high for exactly the cycle after an edge at which bit 1 changed while smi_en was high. It stays low when bit 1 does not change or when smi_en was low.
- R7: warm_rst_req is high for one cycle after an edge at which bit 0 went from 0 to 1. Writing 1 while bit 0 is already 1 gives no pulse. After bit 0 is cleared, a new 1 pulses again.
- R8: io_rdata returns the register contents in the same cycle while io_rd is high and io_addr equals 092h. Otherwise io_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not selected |
| kbd_upd | input | 1 | Keyboard-monitor update strobe for bit 1 |
| kbd_a20 | input | 1 | Value the keyboard monitor loads into bit 1 |
| smi_en | input | 1 | Enables the event pulse on a bit 1 change |
| a20_mask_n | output | 1 | Active-low A20 mask, equal to bit 1 |
| warm_rst_req | output | 1 | One-cycle fast warm-reset request |
| smi_a20_evt | output | 1 | One-cycle event on a bit 1 change |

## Verification
The bench visits every starting value of the two live bits. For each one it writes every byte value, with the event enable both low and high. This catches a design that stores reserved bits, that fires the event on a write of an unchanged value, or that pulses reset again while bit 0 is already set. Further cases cover a keyboard update alone and a keyboard update in the same cycle as a conflicting bus write; a design with the wrong priority leaves the keyboard value in bit 1. Writes to neighbouring addresses such as 093h and 192h would alter the register if the decoder compared too few address bits.

// File: rtl/porta_pkg.sv
package porta_pkg;
   // Bit positions software depends on
   localparam int unsigned A20_POS = 1;
   localparam int unsigned RST_POS = 0;
   localparam int unsigned LIVE_BITS = 2;

   typedef struct packed {
      logic a20;
      logic rst;
   } porta_state_t;
endpackage

// File: rtl/porta_decode.sv
module porta_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic              wr_hit,
   output logic              rd_hit
);
   logic sel;

   // Full-width compare: aliases must not decode
   assign sel    = (io_addr == PORT_ADDR);
   assign wr_hit = io_wr & sel;
   assign rd_hit = io_rd & sel;
endmodule

// File: rtl/porta_bits.sv
module porta_bits
   import porta_pkg::*;
#(
   parameter porta_state_t RST_STATE = '{a20: 1'b1, rst: 1'b0}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic         wr_a20,
   input  logic         wr_rst,
   input  logic         kbd_upd,
   input  logic         kbd_a20,
   output porta_state_t cur,
   output porta_state_t nxt
);
   always_comb begin
      nxt = cur;
      if (kbd_upd) begin
         nxt.a20 = kbd_a20;
      end
      // The bus write is applied last, so it wins a same-cycle conflict
      if (wr_hit) begin
         nxt.a20 = wr_a20;
         nxt.rst = wr_rst;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= RST_STATE;
      end else begin
         cur <= nxt;
      end
   end
endmodule

// File: rtl/porta_events.sv
module porta_events
   import porta_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  porta_state_t cur,
   input  porta_state_t nxt,
   input  logic         smi_en,
   output logic         smi_evt,
   output logic         rst_req
);
   logic a20_flip;
   logic rst_rise;

   assign a20_flip = cur.a20 ^ nxt.a20;
   assign rst_rise = ~cur.rst & nxt.rst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smi_evt <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         smi_evt <= smi_en & a20_flip;
         rst_req <= rst_rise;
      end
   end
endmodule

// File: rtl/porta_ctl_reg.sv
module porta_ctl_reg
   import porta_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92,
   parameter logic [DATA_W-1:0] RESET_VAL = 'h02,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              kbd_upd,
   input  logic              kbd_a20,
   input  logic              smi_en,
   output logic              a20_mask_n,
   output logic              warm_rst_req,
   output logic              smi_a20_evt
);
   localparam int unsigned RSV_W = DATA_W - LIVE_BITS;
   localparam porta_state_t RST_STATE = '{a20: RESET_VAL[A20_POS], rst: RESET_VAL[RST_POS]};

   // Elaboration-time parameter checks
   if (DATA_W < LIVE_BITS) begin : g_bad_width
      $error("porta_ctl_reg: DATA_W must hold the two live bits");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("porta_ctl_reg: ADDR_W must be nonzero");
   end
   if (RESET_VAL[DATA_W-1:LIVE_BITS] != '0) begin : g_bad_rst
      $error("porta_ctl_reg: reserved reset bits must be zero");
   end

   logic         wr_hit;
   logic         rd_hit;
   porta_state_t cur;
   porta_state_t nxt;
   logic         rst_bit_q;
   logic [DATA_W-1:0] rd_word;

   porta_decode #(
      .ADDR_W   (ADDR_W),
      .PORT_ADDR(PORT_ADDR)
   ) u_dec (
      .io_addr(io_addr),
      .io_wr  (io_wr),
      .io_rd  (io_rd),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   porta_bits #(
      .RST_STATE(RST_STATE)
   ) u_bits (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wr_a20 (io_wdata[A20_POS]),
      .wr_rst (io_wdata[RST_POS]),
      .kbd_upd(kbd_upd),
      .kbd_a20(kbd_a20),
      .cur    (cur),
      .nxt    (nxt)
   );

   porta_events u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur    (cur),
      .nxt    (nxt),
      .smi_en (smi_en),
      .smi_evt(smi_a20_evt),
      .rst_req(warm_rst_req)
   );

   assign a20_mask_n = cur.a20;
   assign rst_bit_q  = cur.rst;

   // Reserved field is tied to zero; only the live bits are placed
   always_comb begin
      rd_word = {{RSV_W{1'b0}}, cur.a20, cur.rst};
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else begin
            rdata_q <= rd_hit ? rd_word : '0;
         end
      end
      assign io_rdata = rdata_q;
   end else begin : g_rd_comb
      assign io_rdata = rd_hit ? rd_word : '0;
   end
endmodule

// File: rtl/porta_ctl_chk.sv
module porta_ctl_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_rdata,
   input logic              kbd_upd,
   input logic              smi_en,
   input logic              a20_mask_n,
   input logic              warm_rst_req,
   input logic              smi_a20_evt,
   input logic              rst_bit
);
   assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdata[DATA_W-1:2] == '0);

   assert_mask_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(a20_mask_n) |-> ($past(io_wr) || $past(kbd_upd)));

   assert_smi_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      smi_a20_evt |-> ((a20_mask_n != $past(a20_mask_n)) && $past(smi_en)));

   assert_smi_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((a20_mask_n != $past(a20_mask_n)) && $past(smi_en)) |-> smi_a20_evt);

   assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |=> !warm_rst_req);

   assert_rst_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |-> (rst_bit && !$past(rst_bit)));

   assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_rd && !$past(io_rd)) |-> (io_rdata == '0));
endmodule

bind porta_ctl_reg porta_ctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_wr       (io_wr),
   .io_rd       (io_rd),
   .io_rdata    (io_rdata),
   .kbd_upd     (kbd_upd),
   .smi_en      (smi_en),
   .a20_mask_n  (a20_mask_n),
   .warm_rst_req(warm_rst_req),
   .smi_a20_evt (smi_a20_evt),
   .rst_bit     (rst_bit_q)
);

// File: tb/sim_porta_ctl_reg.sv
module sim_porta_ctl_reg;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [15:0] PA = 16'h0092;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        kbd_upd = 1'b0;
   logic        kbd_a20 = 1'b0;
   logic        smi_en = 1'b0;
   logic        a20_mask_n;
   logic        warm_rst_req;
   logic        smi_a20_evt;

   int errors = 0;
   int checks = 0;
   logic m_a20;
   logic m_rst;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   porta_ctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .kbd_upd(kbd_upd), .kbd_a20(kbd_a20),
      .smi_en(smi_en), .a20_mask_n(a20_mask_n), .warm_rst_req(warm_rst_req),
      .smi_a20_evt(smi_a20_evt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a negedge; one access cycle, returns at the next negedge
   // with the pulses checked against the model.
   task automatic cycle(input logic [15:0] a, input logic wr, input logic [7:0] d,
                        input logic ku, input logic kv, input logic en, input string req);
      logic hit, na20, nrst, esmi, ewr;
      hit  = wr && (a == PA);
      na20 = hit ? d[1] : (ku ? kv : m_a20);
      nrst = hit ? d[0] : m_rst;
      esmi = en && (na20 != m_a20);
      ewr  = nrst && !m_rst;
      io_addr = a; io_wr = wr; io_wdata = d; kbd_upd = ku; kbd_a20 = kv; smi_en = en;
      @(posedge clk);
      @(negedge clk);
      io_wr = 1'b0; kbd_upd = 1'b0; smi_en = 1'b0;
      m_a20 = na20; m_rst = nrst;
      chk({req, " smi R6"}, 32'(smi_a20_evt), 32'(esmi));
      chk({req, " wrst R7"}, 32'(warm_rst_req), 32'(ewr));
      chk({req, " mask R4"}, 32'(a20_mask_n), 32'(m_a20));
   endtask

   task automatic rd_check(input string req);
      io_addr = PA; io_rd = 1'b1;
      #1;
      chk({req, " read R2 R3 R8"}, 32'(io_rdata), {30'd0, m_a20, m_rst});
      io_rd = 1'b0;
      #1;
      chk({req, " idle R8"}, 32'(io_rdata), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_a20 = 1'b1; m_rst = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 mask", 32'(a20_mask_n), 32'd1);
      chk("R1 wrst", 32'(warm_rst_req), 32'd0);
      chk("R1 smi", 32'(smi_a20_evt), 32'd0);
      io_addr = PA; io_rd = 1'b1; #1;
      chk("R1 read", 32'(io_rdata), 32'h02);
      io_rd = 1'b0; #1;
      // Read at a neighbouring address returns 0 (R8)
      io_addr = 16'h0093; io_rd = 1'b1; #1;
      chk("R8 other addr read", 32'(io_rdata), 32'd0);
      io_rd = 1'b0;
      @(negedge clk);

      // Near-exhaustive sweep: every start value x every byte x enable
      for (int p = 0; p < 4; p++) begin
         for (int d = 0; d < 256; d++) begin
            for (int e = 0; e < 2; e++) begin
               cycle(PA, 1'b1, 8'(p), 1'b0, 1'b0, 1'b0, "R2 preset");
               cycle(PA, 1'b1, 8'(d), 1'b0, 1'b0, e[0], "R2 sweep");
               rd_check("R3 sweep");
            end
         end
      end

      // Keyboard updates alone (R5)
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 2; v++) begin
            for (int e = 0; e < 2; e++) begin
               cycle(PA, 1'b1, {6'd0, s[0], 1'b0}, 1'b0, 1'b0, 1'b0, "R5 preset");
               cycle(PA, 1'b0, 8'h00, 1'b1, v[0], e[0], "R5 kbd");
               rd_check("R5 kbd");
            end
         end
      end

      // Same-cycle conflict: bus write wins (R5)
      cycle(PA, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, "R5 preset");
      cycle(PA, 1'b1, 8'h02, 1'b1, 1'b0, 1'b1, "R5 conflict keep");
      chk("R5 conflict keep val", 32'(a20_mask_n), 32'd1);
      cycle(PA, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, "R5 conflict clear");
      chk("R5 conflict clear val", 32'(a20_mask_n), 32'd0);

      // Wrong address writes have no effect (R2)
      cycle(16'h0093, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, "R2 addr 093");
      cycle(16'h0192, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, "R2 addr 192");
      rd_check("R2 alias");
      chk("R2 alias state", 32'(a20_mask_n), 32'd0);

      // Reset rearm sequence (R7)
      cycle(PA, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, "R7 first");
      chk("R7 first pulse seen", 32'(warm_rst_req), 32'd1);
      cycle(PA, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, "R7 repeat");
      chk("R7 no repeat pulse", 32'(warm_rst_req), 32'd0);
      cycle(PA, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R7 clear");
      cycle(PA, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, "R7 rearm");
      chk("R7 rearm pulse", 32'(warm_rst_req), 32'd1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule